// File: doc/BRIEF.md
# Conversion Result Post-Processor

This block sits behind an analog-to-digital converter and conditions its 10-bit results before software or other hardware reads them. Results arrive on a valid/ready stream. The block adds them into one saturating 16-bit accumulator and counts them. It presents a filtered value, which is the accumulator shifted right by a programmable amount. A one-clock done pulse marks each new filtered value.

One shared accumulator serves five behaviours. Basic mode passes each result straight through. Accumulate mode keeps a running sum. Average mode closes a window after a programmed number of samples. Burst mode does the same averaging, but a single trigger requests conversions back to back until the window closes. Low-pass mode runs a first-order recursive filter whose order is set by the shift value.

A small parallel configuration port writes the mode, the shift, the repeat target and a clear strobe. The back-pressure rule is simple: `s_ready` is low in exactly the cycles in which a configuration write is presented. A result is accepted only in a cycle where both `s_valid` and `s_ready` are high. The source must hold its data until that happens.

Top module: `conv_postproc`

## Requirements
- R1: After reset, `result`, `acc_out` and `count` are 0, `done` and `conv_req` are low and `s_ready` is high. The mode register resets to basic, the shift register to 0 and the repeat register to 0.
- R2: A result is taken only in a cycle where `s_valid` and `s_ready` are both high. `s_ready` is low in every cycle in which `cfg_we` is high, and a result offered in such a cycle changes neither the accumulator nor the counter.
- R3: Basic mode: an accepted result X sets `acc_out` to X and `result` to X, with no shift applied. `count` is left unchanged.
- R4: Accumulate mode: an accepted X adds X into `acc_out`, saturating at 0xFFFF. `count` increments, saturating at 255. Writing address 3 with bit 0 set clears both `acc_out` and `count` in any mode.
- R5: The shift register is written at address 1, data bits [2:0]. `result` equals the accumulator shifted right by that value, and a value of 7 acts as 6.
- R6: Average mode: the repeat target is written at address 2, where 0 acts as 1. The first sample after a finished window restarts both the sum and the count from zero. When `count` reaches the target, `result` takes the shifted sum and `done` pulses. Between those points `result` holds its value and `done` stays low.
- R7: Burst mode: a rising edge on `trig` while `conv_req` is low raises `conv_req` and restarts the window. `conv_req` stays high until the sample that completes the window has been accepted.
- R8: Low-pass mode: each accepted X sets the accumulator to acc - (acc >> shift) + X, saturating at 0xFFFF. `result` is the new accumulator shifted right by the shift, and `count` increments with saturation.
- R9: In the non-burst modes, a rising edge on `trig` raises `conv_req`, and the next accepted result lowers it. Trigger edges while `conv_req` is high are ignored.
- R10: The mode register is written at address 0, data bits [2:0]. The encoding is 0 basic, 1 accumulate, 2 average, 3 burst and 4 low-pass, and the codes 5 to 7 behave as basic.
- R11: `done` is registered and high for exactly the cycle after the clock edge that accepted the result it reports. In basic, accumulate and low-pass modes it pulses for every accepted result. A run of accepted results gives a run of pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address: 0 mode, 1 shift, 2 repeat, 3 clear |
| cfg_wdata | input | 8 | Configuration write data |
| trig | input | 1 | Conversion trigger, acting on its rising edge |
| conv_req | output | 1 | Request for conversions toward the converter |
| s_valid | input | 1 | Conversion result valid |
| s_ready | output | 1 | Block can accept a result |
| s_data | input | 10 | Conversion result |
| result | output | 16 | Filtered value |
| done | output | 1 | One-cycle pulse marking a new filtered value |
| acc_out | output | 16 | Current accumulator |
| count | output | 8 | Samples summed in the current run or window |

## Verification
A corrupted accumulator or counter shows at `acc_out` and `count` on the clock edge right after the faulty update. In average and burst modes it also shows later, as a wrong window length or a wrong `result` at the next `done`. A wrong window bound moves the `done` pulse by whole samples. A broken request latch in burst mode shows as `conv_req` staying high, or falling early, within one cycle of the closing sample. The bench compares every output against a behavioural model on every clock, so any such divergence is reported in the cycle where it first appears.

// File: rtl/cpp_pkg.sv
package cpp_pkg;

  typedef enum logic [2:0] {
    PP_BASIC = 3'd0,
    PP_ACCUM = 3'd1,
    PP_AVG   = 3'd2,
    PP_BURST = 3'd3,
    PP_LPF   = 3'd4
  } pp_mode_e;

  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_SHIFT = 2'd1;
  localparam logic [1:0] ADDR_RPT   = 2'd2;
  localparam logic [1:0] ADDR_CLR   = 2'd3;

  // map a raw mode code onto the enum; unused codes fall back to basic
  function automatic pp_mode_e decode_mode(input logic [2:0] code);
    pp_mode_e m;
    case (code)
      3'd1:    m = PP_ACCUM;
      3'd2:    m = PP_AVG;
      3'd3:    m = PP_BURST;
      3'd4:    m = PP_LPF;
      default: m = PP_BASIC;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cpp_cfg.sv
module cpp_cfg
  import cpp_pkg::*;
#(
  parameter int CW        = 8,
  parameter int SHW       = 3,
  parameter int MAX_SHIFT = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [1:0]     addr,
  input  logic [CW-1:0]  wdata,
  output pp_mode_e       mode,
  output logic [SHW-1:0] shift_eff,
  output logic [CW-1:0]  rpt_eff,
  output logic           clr
);

  localparam logic [SHW-1:0] SH_CAP = SHW'(MAX_SHIFT);

  logic [2:0]     mode_q;
  logic [SHW-1:0] shift_q;
  logic [CW-1:0]  rpt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      shift_q <= '0;
      rpt_q   <= '0;
    end else if (we) begin
      case (addr)
        ADDR_MODE:  mode_q  <= wdata[2:0];
        ADDR_SHIFT: shift_q <= wdata[SHW-1:0];
        ADDR_RPT:   rpt_q   <= wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    mode      = decode_mode(mode_q);
    shift_eff = (shift_q > SH_CAP) ? SH_CAP : shift_q;
    rpt_eff   = (rpt_q == '0) ? CW'(1) : rpt_q;
    clr       = we && (addr == ADDR_CLR) && wdata[0];
  end

endmodule

// File: rtl/cpp_seq.sv
module cpp_seq
  import cpp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     trig,
  input  pp_mode_e mode,
  input  logic     accept,
  input  logic     win_done,
  output logic     conv_req,
  output logic     restart
);

  logic trig_q;
  logic req_q;
  logic rise;
  logic req_end;

  always_comb begin
    rise     = trig && !trig_q;
    restart  = rise && !req_q && (mode == PP_BURST);
    // a burst request lives until its window closes, others for one sample
    req_end  = (mode == PP_BURST) ? win_done : accept;
    conv_req = req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      trig_q <= trig;
      if (req_q) begin
        if (req_end) req_q <= 1'b0;
      end else if (rise) begin
        req_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/cpp_datapath.sv
module cpp_datapath
  import cpp_pkg::*;
#(
  parameter int DW  = 10,
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int SHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  pp_mode_e       mode,
  input  logic [SHW-1:0] shift,
  input  logic [CW-1:0]  rpt,
  input  logic           clr,
  input  logic           restart,
  input  logic           accept,
  input  logic [DW-1:0]  sample,
  output logic [AW-1:0]  acc,
  output logic [CW-1:0]  cnt,
  output logic [AW-1:0]  result,
  output logic           done,
  output logic           win_done
);

  localparam logic [AW-1:0] ACC_MAX = {AW{1'b1}};
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [AW-1:0] acc_n, res_n, base_a, x_ext, lp_keep;
  logic [CW-1:0] cnt_n, base_c;
  logic [AW:0]   sum;
  logic          done_n, win_full;

  always_comb begin
    x_ext    = {{(AW-DW){1'b0}}, sample};
    win_full = (cnt >= rpt);
    acc_n    = acc;
    cnt_n    = cnt;
    res_n    = result;
    done_n   = 1'b0;
    win_done = 1'b0;
    base_a   = acc;
    base_c   = cnt;
    lp_keep  = acc - (acc >> shift);
    sum      = '0;
    if (clr) begin
      acc_n = '0;
      cnt_n = '0;
    end else if (accept) begin
      case (mode)
        PP_ACCUM: begin
          sum    = {1'b0, acc} + {1'b0, x_ext};
          acc_n  = sum[AW] ? ACC_MAX : sum[AW-1:0];
          cnt_n  = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
          res_n  = acc_n >> shift;
          done_n = 1'b1;
        end
        PP_AVG, PP_BURST: begin
          if (restart || win_full) begin
            base_a = '0;
            base_c = '0;
          end
          sum   = {1'b0, base_a} + {1'b0, x_ext};
          acc_n = sum[AW] ? ACC_MAX : sum[AW-1:0];
          cnt_n = base_c + 1'b1;
          if (cnt_n == rpt) begin
            res_n    = acc_n >> shift;
            done_n   = 1'b1;
            win_done = 1'b1;
          end
        end
        PP_LPF: begin
          sum    = {1'b0, lp_keep} + {1'b0, x_ext};
          acc_n  = sum[AW] ? ACC_MAX : sum[AW-1:0];
          cnt_n  = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
          res_n  = acc_n >> shift;
          done_n = 1'b1;
        end
        default: begin
          acc_n  = x_ext;
          res_n  = x_ext;
          done_n = 1'b1;
        end
      endcase
    end else if (restart) begin
      acc_n = '0;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      cnt    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      acc    <= acc_n;
      cnt    <= cnt_n;
      result <= res_n;
      done   <= done_n;
    end
  end

endmodule

// File: rtl/conv_postproc.sv
module conv_postproc
  import cpp_pkg::*;
#(
  parameter int DW        = 10,
  parameter int AW        = 16,
  parameter int CW        = 8,
  parameter int SHW       = 3,
  parameter int MAX_SHIFT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          trig,
  output logic          conv_req,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  output logic [AW-1:0] result,
  output logic          done,
  output logic [AW-1:0] acc_out,
  output logic [CW-1:0] count
);

  pp_mode_e       mode;
  logic [SHW-1:0] shift_eff;
  logic [CW-1:0]  rpt_eff;
  logic           clr, restart, accept, win_done;

  // configuration writes take the cycle; the stream waits
  assign s_ready = !cfg_we;
  assign accept  = s_valid && s_ready;

  cpp_cfg #(.CW(CW), .SHW(SHW), .MAX_SHIFT(MAX_SHIFT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .mode(mode), .shift_eff(shift_eff), .rpt_eff(rpt_eff), .clr(clr)
  );

  cpp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .mode(mode), .accept(accept),
    .win_done(win_done), .conv_req(conv_req), .restart(restart)
  );

  cpp_datapath #(.DW(DW), .AW(AW), .CW(CW), .SHW(SHW)) u_dp (
    .clk(clk), .rst_n(rst_n), .mode(mode), .shift(shift_eff), .rpt(rpt_eff),
    .clr(clr), .restart(restart), .accept(accept), .sample(s_data),
    .acc(acc_out), .cnt(count), .result(result), .done(done), .win_done(win_done)
  );

endmodule

// File: rtl/cpp_chk.sv
module cpp_chk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          trig,
  input logic          conv_req,
  input logic          s_valid,
  input logic          s_ready,
  input logic [AW-1:0] result,
  input logic          done,
  input logic [CW-1:0] count
);

  // R11
  done_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(s_valid && s_ready));

  // R2
  write_blocks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !done);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R9
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_req) |-> $past(s_valid && s_ready));

  // R4
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(s_valid && s_ready) && !cfg_we && !trig) |=> $stable(count));

endmodule

bind conv_postproc cpp_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .trig(trig), .conv_req(conv_req),
  .s_valid(s_valid), .s_ready(s_ready), .result(result), .done(done), .count(count)
);

// File: tb/conv_postproc_bench.sv
`timescale 1ns/1ps
module conv_postproc_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic trig = 1'b0;
  logic s_valid = 1'b0;
  logic [9:0] s_data = '0;
  logic conv_req, s_ready, done;
  logic [15:0] result, acc_out;
  logic [7:0] count;

  int n_chk = 0;
  int n_bad = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  conv_postproc u_conv_postproc (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig(trig), .conv_req(conv_req), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .result(result), .done(done),
    .acc_out(acc_out), .count(count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced once per rising edge
  int  m_acc = 0, m_cnt = 0, m_res = 0, m_mode = 0, m_sh = 0, m_rpt = 0;
  bit  m_done = 0, m_req = 0, m_trq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_cnt = 0; m_res = 0; m_mode = 0; m_sh = 0; m_rpt = 0;
      m_done = 0; m_req = 0; m_trq = 0;
    end else begin
      bit take, rise, rs, wd;
      int md, shv, rp, a, c;
      take = s_valid && !cfg_we;
      rise = trig && !m_trq;
      md   = (m_mode > 4) ? 0 : m_mode;
      shv  = (m_sh > 6) ? 6 : m_sh;
      rp   = (m_rpt == 0) ? 1 : m_rpt;
      rs   = rise && !m_req && md == 3;
      wd   = 0;
      m_done = 0;
      if (cfg_we && cfg_addr == 3 && cfg_wdata[0]) begin
        m_acc = 0; m_cnt = 0;
      end else if (take) begin
        if (md == 1) begin
          m_acc = m_acc + s_data; if (m_acc > 65535) m_acc = 65535;
          m_cnt = (m_cnt >= 255) ? 255 : m_cnt + 1;
          m_res = m_acc >> shv; m_done = 1;
        end else if (md == 2 || md == 3) begin
          a = m_acc; c = m_cnt;
          if (rs || c >= rp) begin a = 0; c = 0; end
          a = a + s_data; if (a > 65535) a = 65535;
          c = c + 1;
          m_acc = a; m_cnt = c;
          if (c == rp) begin m_res = a >> shv; m_done = 1; wd = 1; end
        end else if (md == 4) begin
          m_acc = m_acc - (m_acc >> shv) + s_data; if (m_acc > 65535) m_acc = 65535;
          m_cnt = (m_cnt >= 255) ? 255 : m_cnt + 1;
          m_res = m_acc >> shv; m_done = 1;
        end else begin
          m_acc = s_data; m_res = s_data; m_done = 1;
        end
      end else if (rs) begin
        m_acc = 0; m_cnt = 0;
      end
      if (m_req) begin
        if ((md == 3) ? wd : take) m_req = 0;
      end else if (rise) m_req = 1;
      m_trq = trig;
      if (cfg_we) begin
        if (cfg_addr == 0) m_mode = cfg_wdata & 7;
        else if (cfg_addr == 1) m_sh = cfg_wdata & 7;
        else if (cfg_addr == 2) m_rpt = cfg_wdata;
      end
    end
    #1;
    if (rst_n) begin
      chk({phase, " result"}, result, m_res);
      chk({phase, " done"}, done, m_done);
      chk({phase, " acc_out"}, acc_out, m_acc);
      chk({phase, " count"}, count, m_cnt);
      chk({phase, " conv_req"}, conv_req, m_req);
      chk({phase, " s_ready"}, s_ready, !cfg_we);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); cfg_we = 1; cfg_addr = 2'(a); cfg_wdata = 8'(d);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send(input int x);
    @(negedge clk); s_valid = 1; s_data = 10'(x);
    @(negedge clk); s_valid = 0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 result", result, 0); chk("R1 acc_out", acc_out, 0);
    chk("R1 count", count, 0);   chk("R1 done", done, 0);
    chk("R1 conv_req", conv_req, 0); chk("R1 s_ready", s_ready, 1);
    rst_n = 1;

    phase = "R3";
    send(341);
    chk("R3 result", result, 341); chk("R3 done", done, 1); chk("R3 count", count, 0);
    @(negedge clk); chk("R11 done drops", done, 0);

    phase = "R4";
    wr(0, 1); wr(3, 1); wr(1, 2);
    send(100); send(200); send(300);
    chk("R4 acc_out", acc_out, 600); chk("R5 result shift2", result, 150);
    chk("R4 count", count, 3);
    phase = "R5";
    wr(1, 7);
    send(0);
    chk("R5 shift7 as 6", result, 9);
    phase = "R4";
    @(negedge clk); s_valid = 1; s_data = 10'd1023;
    repeat (70) @(negedge clk);
    s_data = 10'd0;
    repeat (190) @(negedge clk);
    s_valid = 0;
    chk("R4 acc saturate", acc_out, 65535);
    chk("R4 count saturate", count, 255);
    chk("R11 run of pulses", done, 1);

    phase = "R6";
    wr(0, 2); wr(2, 4); wr(1, 2);
    send(10); send(20); send(30);
    chk("R6 mid window done", done, 0); chk("R6 mid window hold", result, 1023);
    send(40);
    chk("R6 average", result, 25); chk("R6 done", done, 1);
    for (int i = 0; i < 4; i++) send(100);
    chk("R6 second window", result, 100);
    wr(2, 0);
    send(400);
    chk("R6 repeat zero as one", result, 100);
    send(8);
    chk("R6 repeat zero done", result, 2);

    phase = "R7";
    wr(0, 3); wr(2, 8); wr(1, 3);
    pulse_trig();
    chk("R7 req raised", conv_req, 1);
    s_valid = 1; s_data = 10'd50;
    for (int i = 0; i < 20 && conv_req; i++) @(negedge clk);
    s_valid = 0;
    chk("R7 req dropped", conv_req, 0);
    chk("R7 burst average", result, 50);
    chk("R7 burst count", count, 8);

    phase = "R9";
    wr(0, 0);
    pulse_trig();
    chk("R9 req raised", conv_req, 1);
    pulse_trig();
    chk("R9 second edge ignored", conv_req, 1);
    send(7);
    chk("R9 req cleared", conv_req, 0);

    phase = "R2";
    wr(0, 1); wr(3, 1);
    @(negedge clk); cfg_we = 1; cfg_addr = 2'd2; cfg_wdata = 8'd4; s_valid = 1; s_data = 10'd5;
    #0.5; chk("R2 ready low on write", s_ready, 0);
    @(negedge clk); cfg_we = 0;
    chk("R2 stalled count", count, 0); chk("R2 stalled acc", acc_out, 0);
    @(negedge clk); s_valid = 0;
    chk("R2 taken count", count, 1); chk("R2 taken acc", acc_out, 5);

    phase = "R8";
    wr(0, 4); wr(1, 2); wr(3, 1);
    send(1000);
    chk("R8 first acc", acc_out, 1000); chk("R8 first result", result, 250);
    send(1000);
    chk("R8 second acc", acc_out, 1750); chk("R8 second result", result, 437);
    for (int i = 0; i < 30; i++) send(i * 31);

    phase = "R10";
    wr(0, 5);
    send(682);
    chk("R10 code 5 basic", result, 682); chk("R10 code 5 acc", acc_out, 682);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule